// File: doc/BRIEF.md
# Indirect Interrupt Routing Register Window

This block is the register front end of an interrupt routing controller. Software reaches all of its state through two 32-bit bus locations: a select location that holds an 8-bit index, and a data window that reads or writes whatever register that index names. Behind the window sit a 4-bit controller identifier, a read-only version word, and a table of 64-bit routing entries, one per interrupt pin. Each entry is split into a lower and an upper 32-bit half, and the two halves sit at two consecutive indices.

The full table is exported on a flat bus to the routing logic beside the block. Two plain one-cycle pulses also go to that logic. A mask-change event reports which entry's mask bit a window write flipped, and the mask's new value. A service request names a pin that had its entry written while its request line was pending. Neither pulse can be held off by a receiver. Each is valid for exactly one cycle and carries no ready. The delivery logic raises a remote-status set line for an entry it has delivered a level interrupt from. Bus accesses are single-cycle: a write takes effect at the clock edge where it is presented, and read data is combinational in the cycle the read is presented.

Top module: `irq_route_window`

## Requirements
- R1: After reset the select register is 0, the identifier is 0, and every table entry equals 64'h0000_0000_0001_0000, meaning only mask bit 16 is set. Both output pulses are low.
- R2: A write at bus offset 0x00 stores the low 8 data bits in the select register. A read at offset 0x00 returns that value zero-extended.
- R3: Window index 0x01 reads as {8'h00, NPINS-1, 8'h00, VERSION}, which is 32'h0017_0011 with the defaults. Writes to it have no effect.
- R4: A window write at index 0x00 stores data bits 27:24 as the identifier. Indices 0x00 and 0x02 both read the identifier in bits 27:24 with all other bits zero. Writes at index 0x02 have no effect.
- R5: An index of 0x10 or more names entry (index-0x10)>>1, and index bit 0 picks the upper half (1) or the lower half (0). Window reads and writes act on that half. An entry number at or beyond NPINS reads 0 and drops writes. Indices 0x03 to 0x0F read 0.
- R6: Bit 14 of an entry is its remote status bit. A rirr_hit pulse sets it. A lower-half write clears it, whatever data bit 14 holds. An upper-half write leaves it unchanged.
- R7: A window write that changes an entry's mask bit (bit 16) raises mask_evt_valid for exactly one cycle after the write edge, with the entry number and the new mask value. A write that leaves the mask unchanged raises no event.
- R8: Writes whose bus_size (a byte count) is neither 4 nor 8 are dropped at both offsets.
- R9: Only bus_addr[7:0] is decoded, so 0x100 aliases 0x00 and 0x110 aliases 0x10. Reads at any other offset return 0.
- R10: After a table write edge, if irq_pend for that entry is high in the next cycle, svc_valid is high with svc_idx equal to the entry number in the cycle after that, for one cycle.
- R11: tbl_flat[64*e +: 64] carries entry e.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Write strobe, one access per cycle |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address; low 8 bits decoded |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational; zero when no read |
| irq_pend | input | NPINS | Per-pin pending request lines |
| rirr_hit | input | NPINS | Per-entry remote status set pulses |
| tbl_flat | output | 64*NPINS | All table entries, entry e at bits 64e+63:64e |
| mask_evt_valid | output | 1 | Mask-change event pulse |
| mask_evt_idx | output | 7 | Entry whose mask changed |
| mask_evt_val | output | 1 | New mask value |
| svc_valid | output | 1 | Service request pulse |
| svc_idx | output | 7 | Pin to service |

## Verification
The mask-change event and the service request can both be valid in the same cycle. This happens when two lower-half writes to the same pending entry follow each other on consecutive edges, and the second one flips the mask. The bench issues such a pair back to back with the pin's request line held high. In the cycle after the second write it expects the event for the second write and the service request from the first write together, both naming the same entry. One cycle later it expects only the service request caused by the second write.

// File: rtl/irw_pkg.sv
package irw_pkg;
  localparam int EW = 7;
  localparam logic [7:0] OFF_SELECT = 8'h00;
  localparam logic [7:0] OFF_WINDOW = 8'h10;
  localparam logic [7:0] IX_IDENT   = 8'h00;
  localparam logic [7:0] IX_VERSION = 8'h01;
  localparam logic [7:0] IX_ARBIT   = 8'h02;
  localparam logic [7:0] IX_TABLE   = 8'h10;
  localparam int MASK_POS = 16;
  localparam int RIRR_POS = 14;
  localparam logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000;

  typedef enum logic [1:0] {TGT_NONE, TGT_IDENT, TGT_VERSION, TGT_TABLE} win_tgt_e;

  typedef struct packed {
    win_tgt_e        tgt;
    logic            wr_ok;
    logic            hi;
    logic [EW-1:0]   ent;
  } win_dec_t;
endpackage

// File: rtl/irw_index_decode.sv
module irw_index_decode
  import irw_pkg::*;
#(
  parameter int NPINS = 24
) (
  input  logic [7:0] sel,
  output win_dec_t   dec
);
  logic [7:0] off;

  always_comb begin
    off       = sel - IX_TABLE;
    dec       = '0;
    dec.tgt   = TGT_NONE;
    dec.hi    = sel[0];
    dec.ent   = off[7:1];
    if (sel == IX_IDENT) begin
      dec.tgt   = TGT_IDENT;
      dec.wr_ok = 1'b1;
    end else if (sel == IX_ARBIT) begin
      dec.tgt   = TGT_IDENT;
    end else if (sel == IX_VERSION) begin
      dec.tgt   = TGT_VERSION;
    end else if (sel >= IX_TABLE && ({1'b0, off[7:1]} < 8'(NPINS))) begin
      dec.tgt   = TGT_TABLE;
      dec.wr_ok = 1'b1;
    end
  end
endmodule

// File: rtl/irw_entry.sv
module irw_entry
  import irw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  input  logic        rirr_set,
  output logic [63:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= ENTRY_RST;
    end else begin
      if (wr_hi) q[63:32] <= wdata;
      if (wr_lo) begin
        q[31:0]     <= wdata;
        q[RIRR_POS] <= 1'b0;
      end else if (rirr_set) begin
        q[RIRR_POS] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irw_notify.sv
module irw_notify
  import irw_pkg::*;
#(
  parameter int NPINS = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tbl_wr,
  input  logic            lo_wr,
  input  logic [EW-1:0]   ent,
  input  logic            old_mask,
  input  logic            new_mask,
  input  logic [NPINS-1:0] pend,
  output logic            evt_valid,
  output logic [EW-1:0]   evt_idx,
  output logic            evt_val,
  output logic            svc_valid,
  output logic [EW-1:0]   svc_idx
);
  localparam int PW = 1 << EW;
  logic [PW-1:0] pend_ext;
  logic          wr_q;
  logic [EW-1:0] ent_q;

  assign pend_ext = PW'(pend);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_valid <= 1'b0;
      evt_idx   <= '0;
      evt_val   <= 1'b0;
      wr_q      <= 1'b0;
      ent_q     <= '0;
      svc_valid <= 1'b0;
      svc_idx   <= '0;
    end else begin
      evt_valid <= lo_wr && (old_mask != new_mask);
      evt_idx   <= ent;
      evt_val   <= new_mask;
      wr_q      <= tbl_wr;
      ent_q     <= ent;
      svc_valid <= wr_q && pend_ext[ent_q];
      svc_idx   <= ent_q;
    end
  end
endmodule

// File: rtl/irq_route_window.sv
module irq_route_window
  import irw_pkg::*;
#(
  parameter int         NPINS   = 24,
  parameter logic [7:0] VERSION = 8'h11,
  parameter int         ADDR_W  = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr_en,
  input  logic                  bus_rd_en,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [3:0]            bus_size,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NPINS-1:0]      irq_pend,
  input  logic [NPINS-1:0]      rirr_hit,
  output logic [64*NPINS-1:0]   tbl_flat,
  output logic                  mask_evt_valid,
  output logic [EW-1:0]         mask_evt_idx,
  output logic                  mask_evt_val,
  output logic                  svc_valid,
  output logic [EW-1:0]         svc_idx
);
  localparam logic [7:0] TOP_PIN = 8'(NPINS - 1);

  logic [7:0]  off;
  logic        size_ok, wr_acc, wr_sel, wr_win;
  logic [7:0]  sel_q;
  logic [3:0]  id_q;
  win_dec_t    dec;
  logic        tbl_wr, lo_wr, hi_wr;
  logic [63:0] ent_q [NPINS];
  logic [63:0] cur_ent;

  assign off     = bus_addr[7:0];
  assign size_ok = (bus_size == 4'd4) || (bus_size == 4'd8);
  assign wr_acc  = bus_wr_en && size_ok;
  assign wr_sel  = wr_acc && (off == OFF_SELECT);
  assign wr_win  = wr_acc && (off == OFF_WINDOW);

  irw_index_decode #(.NPINS(NPINS)) dec_i (.sel(sel_q), .dec(dec));

  assign tbl_wr = wr_win && (dec.tgt == TGT_TABLE);
  assign lo_wr  = tbl_wr && !dec.hi;
  assign hi_wr  = tbl_wr && dec.hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (wr_sel) sel_q <= bus_wdata[7:0];
      if (wr_win && dec.tgt == TGT_IDENT && dec.wr_ok) id_q <= bus_wdata[27:24];
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_ent
    irw_entry ent_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_lo    (lo_wr && dec.ent == EW'(g)),
      .wr_hi    (hi_wr && dec.ent == EW'(g)),
      .wdata    (bus_wdata),
      .rirr_set (rirr_hit[g]),
      .q        (ent_q[g])
    );
    assign tbl_flat[64*g +: 64] = ent_q[g];
  end

  always_comb begin
    cur_ent = '0;
    for (int i = 0; i < NPINS; i++)
      if (dec.ent == EW'(i)) cur_ent = ent_q[i];
  end

  irw_notify #(.NPINS(NPINS)) ntf_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tbl_wr    (tbl_wr),
    .lo_wr     (lo_wr),
    .ent       (dec.ent),
    .old_mask  (cur_ent[MASK_POS]),
    .new_mask  (bus_wdata[MASK_POS]),
    .pend      (irq_pend),
    .evt_valid (mask_evt_valid),
    .evt_idx   (mask_evt_idx),
    .evt_val   (mask_evt_val),
    .svc_valid (svc_valid),
    .svc_idx   (svc_idx)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd_en) begin
      if (off == OFF_SELECT) begin
        bus_rdata = {24'h0, sel_q};
      end else if (off == OFF_WINDOW) begin
        unique case (dec.tgt)
          TGT_IDENT:   bus_rdata = {4'h0, id_q, 24'h0};
          TGT_VERSION: bus_rdata = {8'h00, TOP_PIN, 8'h00, VERSION};
          TGT_TABLE:   bus_rdata = dec.hi ? cur_ent[63:32] : cur_ent[31:0];
          default:     bus_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/irw_checker.sv
module irw_checker #(
  parameter int NPINS  = 24,
  parameter int ADDR_W = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr_en,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [3:0]          bus_size,
  input logic [7:0]          sel,
  input logic [NPINS-1:0]    rirr_hit,
  input logic [64*NPINS-1:0] tbl_flat,
  input logic                mask_evt_valid,
  input logic [6:0]          mask_evt_idx,
  input logic                mask_evt_val,
  input logic                svc_valid
);
  logic       size_good, win_wr, on_tbl;
  logic [7:0] rel;
  logic [6:0] ent, ent_prev;

  assign size_good = (bus_size == 4'd4) || (bus_size == 4'd8);
  assign win_wr    = bus_wr_en && size_good && (bus_addr[7:0] == 8'h10);
  assign rel       = sel - 8'h10;
  assign ent       = rel[7:1];
  assign on_tbl    = (sel >= 8'h10) && (int'(ent) < NPINS);

  always_ff @(posedge clk) ent_prev <= ent;

  assert_evt_matches_table_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_evt_valid |-> tbl_flat[int'(mask_evt_idx)*64 + 16] == mask_evt_val);

  assert_evt_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_evt_valid |-> $past(win_wr));

  assert_low_write_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && on_tbl && !sel[0]) |=> tbl_flat[int'(ent_prev)*64 + 14] == 1'b0);

  assert_high_write_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && on_tbl && sel[0] && rirr_hit == '0) |=>
      tbl_flat[int'(ent_prev)*64 + 14] == $past(tbl_flat[int'(ent)*64 + 14]));

  assert_bad_size_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && !size_good && rirr_hit == '0) |=> $stable(tbl_flat));

  assert_svc_follows_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> $past(win_wr && on_tbl, 2));
endmodule

bind irq_route_window irw_checker #(.NPINS(NPINS), .ADDR_W(ADDR_W)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .bus_wr_en      (bus_wr_en),
  .bus_addr       (bus_addr),
  .bus_size       (bus_size),
  .sel            (sel_q),
  .rirr_hit       (rirr_hit),
  .tbl_flat       (tbl_flat),
  .mask_evt_valid (mask_evt_valid),
  .mask_evt_idx   (mask_evt_idx),
  .mask_evt_val   (mask_evt_val),
  .svc_valid      (svc_valid)
);

// File: tb/irq_route_window_tb.sv
module irq_route_window_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 24;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [11:0]       bus_addr = '0;
  logic [3:0]        bus_size = 4'd4;
  logic [31:0]       bus_wdata = '0, bus_rdata;
  logic [NP-1:0]     irq_pend = '0, rirr_hit = '0;
  logic [64*NP-1:0]  tbl_flat;
  logic              mask_evt_valid, mask_evt_val, svc_valid;
  logic [6:0]        mask_evt_idx, svc_idx;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_route_window dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_pend(irq_pend), .rirr_hit(rirr_hit),
    .tbl_flat(tbl_flat), .mask_evt_valid(mask_evt_valid),
    .mask_evt_idx(mask_evt_idx), .mask_evt_val(mask_evt_val),
    .svc_valid(svc_valid), .svc_idx(svc_idx)
  );

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [3:0] sz = 4'd4);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_wr_en = 1'b0; bus_size = 4'd4;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    bus_rd_en = 1'b0;
  endtask

  function automatic logic [63:0] entry(int e);
    return tbl_flat[64*e +: 64];
  endfunction

  task automatic t_reset_R1();
    logic [31:0] d;
    chk("R1 evt", mask_evt_valid, 0);
    chk("R1 svc", svc_valid, 0);
    rd(12'h000, d); chk("R1 select", d, 0);
    rd(12'h010, d); chk("R1 ident", d, 0);
    for (int e = 0; e < NP; e++) chk("R1 entry", entry(e), 64'h0000_0000_0001_0000);
  endtask

  task automatic t_select_R2();
    logic [31:0] d;
    wr(12'h000, 32'hABCD_1234);
    rd(12'h000, d); chk("R2 select", d, 32'h34);
    rd(12'h100, d); chk("R9 alias 0x100", d, 32'h34);
  endtask

  task automatic t_version_R3();
    logic [31:0] d;
    wr(12'h000, 32'h01);
    rd(12'h010, d); chk("R3 version", d, 32'h0017_0011);
    wr(12'h010, 32'hFFFF_FFFF);
    rd(12'h010, d); chk("R3 version write ignored", d, 32'h0017_0011);
  endtask

  task automatic t_ident_R4();
    logic [31:0] d;
    wr(12'h000, 32'h00);
    wr(12'h010, 32'h5A00_FFFF);
    rd(12'h010, d); chk("R4 ident", d, 32'h0A00_0000);
    wr(12'h000, 32'h02);
    rd(12'h010, d); chk("R4 arb alias", d, 32'h0A00_0000);
    wr(12'h010, 32'h0300_0000);
    rd(12'h010, d); chk("R4 arb write ignored", d, 32'h0A00_0000);
  endtask

  task automatic t_table_R5();
    logic [31:0] d;
    wr(12'h000, 32'h1A);
    wr(12'h010, 32'h0000_0042);
    rd(12'h010, d); chk("R5 low half", d, 32'h42);
    wr(12'h000, 32'h1B);
    wr(12'h010, 32'hC300_0000);
    rd(12'h010, d); chk("R5 high half", d, 32'hC300_0000);
    chk("R11 flat entry 5", entry(5), 64'hC300_0000_0000_0042);
    wr(12'h000, 32'h40);
    wr(12'h010, 32'h0000_1234);
    rd(12'h010, d); chk("R5 out of range read", d, 0);
    chk("R5 last entry untouched", entry(NP-1), 64'h0000_0000_0001_0000);
    chk("R5 out of range no event", mask_evt_valid, 0);
    wr(12'h000, 32'h05);
    rd(12'h010, d); chk("R5 unused index", d, 0);
  endtask

  task automatic t_rirr_R6();
    logic [31:0] d;
    @(negedge clk); rirr_hit[3] = 1'b1;
    @(negedge clk); rirr_hit[3] = 1'b0;
    chk("R6 set by hit", entry(3)[14], 1);
    wr(12'h000, 32'h17);
    wr(12'h010, 32'hFF00_0000);
    chk("R6 high write keeps", entry(3)[14], 1);
    wr(12'h000, 32'h16);
    wr(12'h010, 32'h0001_4055);
    chk("R7 unchanged mask no event", mask_evt_valid, 0);
    rd(12'h010, d); chk("R6 low write clears", d, 32'h0001_0055);
  endtask

  task automatic t_mask_evt_R7();
    wr(12'h000, 32'h1E);
    wr(12'h010, 32'h0000_0031);
    chk("R7 evt valid", mask_evt_valid, 1);
    chk("R7 evt idx", mask_evt_idx, 7);
    chk("R7 evt val", mask_evt_val, 0);
    @(negedge clk);
    chk("R7 one cycle", mask_evt_valid, 0);
    wr(12'h010, 32'h0001_0031);
    chk("R7 evt set valid", mask_evt_valid, 1);
    chk("R7 evt set val", mask_evt_val, 1);
  endtask

  task automatic t_size_R8();
    logic [31:0] d;
    wr(12'h000, 32'h20, 4'd2);
    rd(12'h000, d); chk("R8 select size 2 dropped", d, 32'h1E);
    wr(12'h010, 32'h0, 4'd1);
    chk("R8 window size 1 dropped", entry(7), 64'h0000_0000_0001_0031);
    chk("R8 no event", mask_evt_valid, 0);
    wr(12'h010, 32'h0001_0077, 4'd8);
    rd(12'h010, d); chk("R8 size 8 accepted", d, 32'h0001_0077);
  endtask

  task automatic t_offsets_R9();
    logic [31:0] d;
    rd(12'h004, d); chk("R9 offset 0x04", d, 0);
    rd(12'h020, d); chk("R9 offset 0x20", d, 0);
    rd(12'h110, d); chk("R9 alias 0x110", d, 32'h0001_0077);
  endtask

  task automatic t_service_R10();
    irq_pend[9] = 1'b1;
    wr(12'h000, 32'h22);
    wr(12'h010, 32'h0001_0099);
    chk("R10 not yet", svc_valid, 0);
    @(negedge clk);
    chk("R10 svc valid", svc_valid, 1);
    chk("R10 svc idx", svc_idx, 9);
    @(negedge clk);
    chk("R10 one cycle", svc_valid, 0);
    wr(12'h000, 32'h24);
    wr(12'h010, 32'h0001_00A0);
    @(negedge clk);
    chk("R10 not pending no svc", svc_valid, 0);
  endtask

  task automatic t_overlap_R7_R10();
    wr(12'h000, 32'h22);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = 12'h010; bus_wdata = 32'h0001_0099;
    @(negedge clk);
    bus_wdata = 32'h0000_0099;
    @(negedge clk);
    bus_wr_en = 1'b0;
    chk("R7 overlap evt", mask_evt_valid, 1);
    chk("R7 overlap evt idx", mask_evt_idx, 9);
    chk("R7 overlap evt val", mask_evt_val, 0);
    chk("R10 overlap svc", svc_valid, 1);
    chk("R10 overlap svc idx", svc_idx, 9);
    @(negedge clk);
    chk("R10 second svc", svc_valid, 1);
    chk("R7 overlap evt gone", mask_evt_valid, 0);
    irq_pend = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_R1();
    t_select_R2();
    t_version_R3();
    t_ident_R4();
    t_table_R5();
    t_rirr_R6();
    t_mask_evt_R7();
    t_size_R8();
    t_offsets_R9();
    t_service_R10();
    t_overlap_R7_R10();
    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule